// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutator

This block turns three Hall-effect position bits from a three-phase brushless motor into six gate-drive signals for the inverter: one high-side and one low-side switch per phase U, V and W. In each 60-degree step of rotation it energises one phase high and another low, leaving the third floating, so six steps make a full electrical turn. The active high-side switch is chopped by an internal 8-bit counter-compare PWM whose duty word comes from outside. The low-side switch stays on for the whole step.

A direction bit reverses rotation by swapping which phase is pulled high and which is pulled low. A run bit turns all six switches off. An over-current comparator bit blanks all six switches at once. The blanking is held until the next PWM period begins, which limits current period by period. Hall codes that cannot occur on a healthy sensor set turn the drive off and raise a fault flag. All single-bit inputs go through two-flop synchronisers, and the outputs leave from registers, so the drive lines do not glitch.

Top module: `bldc_hall_commutator`

## Requirements
- R1: With `hall_i[2]`=H1, `hall_i[1]`=H2, `hall_i[0]`=H3 and phase bit order [0]=U, [1]=V, [2]=W, forward rotation (`dir_i`=0) drives: 100 → U high/V low, 110 → U high/W low, 010 → V high/W low, 011 → V high/U low, 001 → W high/U low, 101 → W high/V low.
- R2: At no cycle is more than one high-side or more than one low-side output on, and the high-side and low-side outputs of the same phase are never on together.
- R3: With `dir_i`=1, each valid code drives the forward table's low phase high and its high phase low.
- R4: While `run_i`=0, all six drive outputs are off.
- R5: Hall codes 000 and 111 turn all six drive outputs off and hold `fault_o`=1 for as long as they persist. A valid code gives `fault_o`=0.
- R6: The PWM period is 256 clocks. In every period the active high-side output is on for exactly `duty_i` clocks (0 means never on), and the active low-side output is on for all of them. `duty_i` is sampled only at the end of a period.
- R7: By the third rising edge after `oc_i` goes high, all six outputs are off. They stay off even if `oc_i` falls, and resume only at the first clock of the next PWM period.
- R8: While `rst_ni` is low, all drive outputs and `fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Hall bits {H1,H2,H3} |
| dir_i | input | 1 | 0 forward, 1 reverse |
| run_i | input | 1 | 1 enables the drive |
| oc_i | input | 1 | Over-current comparator output |
| duty_i | input | 8 | PWM on-time in clocks per 256-clock period |
| hi_o | output | 3 | High-side drives {W,V,U} |
| lo_o | output | 3 | Low-side drives {W,V,U} |
| fault_o | output | 1 | Invalid Hall code flag |

## Verification
On every cycle the assertions check the following: switch exclusivity, the forced-off state under stop, invalid Hall codes and kill, the kill latch holding until the period boundary, and the duty shadow staying constant inside a period. Only the bench scenarios can show the actual phase pairs for each Hall code in both directions and the exact on-time count over a period. The same applies to the exact clock at which a blanked drive comes back after a one-cycle over-current pulse.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  localparam int unsigned PHASES = 3;

  typedef struct packed {
    logic [PHASES-1:0] hi;
    logic [PHASES-1:0] lo;
  } drive_t;

  localparam logic [PHASES-1:0] PH_U = 3'b001;
  localparam logic [PHASES-1:0] PH_V = 3'b010;
  localparam logic [PHASES-1:0] PH_W = 3'b100;
endpackage

// File: rtl/bldc_sync.sv
module bldc_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/bldc_pwm.sv
module bldc_pwm #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, duty_q;

  assign wrap_o = (cnt_q == CNT_MAX);
  assign pwm_o  = (cnt_q < duty_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_o) duty_q <= duty_i;
    end
  end

  // R6
  duty_shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> $stable(duty_q));
endmodule

// File: rtl/bldc_comm_lut.sv
module bldc_comm_lut
  import bldc_pkg::*;
(
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  output drive_t     drive_o,
  output logic       valid_o
);
  drive_t fwd;

  always_comb begin
    valid_o = 1'b1;
    fwd     = '0;
    unique case (hall_i)
      3'b100: begin fwd.hi = PH_U; fwd.lo = PH_V; end
      3'b110: begin fwd.hi = PH_U; fwd.lo = PH_W; end
      3'b010: begin fwd.hi = PH_V; fwd.lo = PH_W; end
      3'b011: begin fwd.hi = PH_V; fwd.lo = PH_U; end
      3'b001: begin fwd.hi = PH_W; fwd.lo = PH_U; end
      3'b101: begin fwd.hi = PH_W; fwd.lo = PH_V; end
      default: valid_o = 1'b0;
    endcase
  end

  // reverse reuses the forward table with roles exchanged
  always_comb begin
    if (dir_i) begin
      drive_o.hi = fwd.lo;
      drive_o.lo = fwd.hi;
    end else begin
      drive_o = fwd;
    end
  end
endmodule

// File: rtl/bldc_kill.sv
module bldc_kill (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic wrap_i,
  output logic kill_o
);
  logic kill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kill_q <= 1'b0;
    else         kill_q <= oc_i | (kill_q & ~wrap_i);
  end

  assign kill_o = oc_i | kill_q;

  // R7
  kill_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_i |=> kill_q);
  // R7
  kill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_q && !wrap_i) |=> kill_q);
endmodule

// File: rtl/bldc_hall_commutator.sv
module bldc_hall_commutator
  import bldc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       hall_i,
  input  logic             dir_i,
  input  logic             run_i,
  input  logic             oc_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [2:0]       hi_o,
  output logic [2:0]       lo_o,
  output logic             fault_o
);
  localparam int unsigned SYNC_W = 6;

  logic [SYNC_W-1:0] sync_s;
  logic [2:0] hall_s;
  logic dir_s, run_s, oc_s;
  logic pwm, wrap, kill, valid;
  drive_t drv;
  logic [2:0] hi_q, lo_q;
  logic fault_q;

  bldc_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({oc_i, run_i, dir_i, hall_i}),
    .q_o   (sync_s)
  );
  assign {oc_s, run_s, dir_s, hall_s} = sync_s;

  bldc_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .duty_i(duty_i),
    .pwm_o (pwm),
    .wrap_o(wrap)
  );

  bldc_comm_lut u_lut (
    .hall_i (hall_s),
    .dir_i  (dir_s),
    .drive_o(drv),
    .valid_o(valid)
  );

  bldc_kill u_kill (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .oc_i  (oc_s),
    .wrap_i(wrap),
    .kill_o(kill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= ~valid;
      if (run_s && valid && !kill) begin
        hi_q <= drv.hi & {3{pwm}};
        lo_q <= drv.lo;
      end else begin
        hi_q <= '0;
        lo_q <= '0;
      end
    end
  end

  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  assign fault_o = fault_q;

  // R2
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hi_o) && $onehot0(lo_o) && ((hi_o & lo_o) == 3'b000));
  // R4
  stop_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_s |=> (hi_o == 3'b000 && lo_o == 3'b000));
  // R5
  bad_hall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |=> (fault_o && hi_o == 3'b000 && lo_o == 3'b000));
  // R7
  kill_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |=> (hi_o == 3'b000 && lo_o == 3'b000));
endmodule

// File: tb/bldc_hall_commutator_bench.sv
module bldc_hall_commutator_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] hall = 3'b100;
  logic dir = 1'b0, run = 1'b0, oc = 1'b0;
  logic [7:0] duty = 8'd0;
  logic [2:0] hi, lo;
  logic fault;

  int total = 0, bad = 0;
  bit done = 0, pending = 0;

  always #2 clk = ~clk;

  bldc_hall_commutator u_bldc_hall_commutator (
    .clk_i(clk), .rst_ni(rst_ni), .hall_i(hall), .dir_i(dir), .run_i(run),
    .oc_i(oc), .duty_i(duty), .hi_o(hi), .lo_o(lo), .fault_o(fault)
  );

  typedef struct {
    logic [2:0] hi;
    logic [2:0] lo;
    logic       fault;
    int         hcnt;
    string      tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic void fwd_map(input logic [2:0] c, output logic [2:0] h, output logic [2:0] l);
    case (c)
      3'b100: begin h = 3'b001; l = 3'b010; end
      3'b110: begin h = 3'b001; l = 3'b100; end
      3'b010: begin h = 3'b010; l = 3'b100; end
      3'b011: begin h = 3'b010; l = 3'b001; end
      3'b001: begin h = 3'b100; l = 3'b001; end
      3'b101: begin h = 3'b100; l = 3'b010; end
      default: begin h = 3'b000; l = 3'b000; end
    endcase
  endfunction

  // driver: apply inputs, let them settle, hand expectation to monitor
  task automatic drive_and_expect(input logic [2:0] c, input logic d, input logic r,
                                  input logic [7:0] dt, input string tag);
    exp_t e;
    logic [2:0] fh, fl;
    logic vld;
    @(negedge clk);
    hall = c; dir = d; run = r; duty = dt;
    repeat (520) @(negedge clk);
    fwd_map(c, fh, fl);
    vld = (c != 3'b000) && (c != 3'b111);
    e.fault = ~vld;
    e.tag = tag;
    if (vld && r) begin
      e.hi   = (dt != 0) ? (d ? fl : fh) : 3'b000;
      e.lo   = d ? fh : fl;
      e.hcnt = dt;
    end else begin
      e.hi = 3'b000; e.lo = 3'b000; e.hcnt = 0;
    end
    q.push_back(e);
    pending = 1;
    wait (pending == 0);
  endtask

  // monitor: observe one full PWM period per expectation
  initial begin
    forever begin
      exp_t e;
      logic [2:0] hor, lor, land;
      logic fall;
      int hc;
      wait (q.size() > 0);
      e = q.pop_front();
      hor = 0; lor = 0; land = 3'b111; fall = 1; hc = 0;
      repeat (256) begin
        @(negedge clk);
        hor |= hi; lor |= lo; land &= lo; fall &= fault;
        if (hi != 0) hc++;
      end
      check(hor == e.hi, {e.tag, " high phase"}, hor, e.hi);
      check(lor == e.lo && land == e.lo, {e.tag, " low phase steady"}, lor, e.lo);
      check(hc == e.hcnt, {e.tag, " on-time"}, hc, e.hcnt);
      check(fall == e.fault, {e.tag, " fault"}, fall, e.fault);
      pending = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [6];
    codes = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
    // R8 reset state
    repeat (4) @(negedge clk);
    check(hi == 0 && lo == 0 && fault == 0, "R8 reset outputs", {fault, hi, lo}, 0);
    @(negedge clk) rst_ni = 1'b1;

    // R1 forward sequence
    foreach (codes[i]) drive_and_expect(codes[i], 1'b0, 1'b1, 8'd128, "R1 fwd");
    // R3 reverse sequence
    foreach (codes[i]) drive_and_expect(codes[i], 1'b1, 1'b1, 8'd128, "R3 rev");
    // R5 invalid codes
    drive_and_expect(3'b000, 1'b0, 1'b1, 8'd128, "R5 code000");
    drive_and_expect(3'b111, 1'b1, 1'b1, 8'd128, "R5 code111");
    drive_and_expect(3'b011, 1'b0, 1'b1, 8'd128, "R5 recover");
    // R4 stop
    drive_and_expect(3'b010, 1'b0, 1'b0, 8'd200, "R4 stopped");
    // R6 duty boundaries
    drive_and_expect(3'b010, 1'b0, 1'b1, 8'd0,   "R6 duty0");
    drive_and_expect(3'b110, 1'b0, 1'b1, 8'd1,   "R6 duty1");
    drive_and_expect(3'b101, 1'b1, 1'b1, 8'd255, "R6 duty255");
    drive_and_expect(3'b100, 1'b0, 1'b1, 8'd77,  "R6 duty77");

    // R7 one-clock over-current pulse blanks the rest of the period
    begin
      int n, lo_bad;
      logic prev;
      drive_and_expect(3'b100, 1'b0, 1'b1, 8'd100, "R7 setup");
      prev = hi[0];
      forever begin
        @(negedge clk);
        if (hi[0] && !prev) break;
        prev = hi[0];
      end
      n = 0; lo_bad = 0;
      while (n < 256) begin
        @(negedge clk); n++;
        if (n == 20) oc = 1'b1;
        if (n == 21) oc = 1'b0;
        if (n >= 23 && n <= 255 && (lo != 0 || hi != 0)) lo_bad++;
        if (n == 22) check(lo == 3'b010, "R7 drive before kill", lo, 3'b010);
      end
      check(lo_bad == 0, "R7 blanked until period end", lo_bad, 0);
      check(hi == 3'b001 && lo == 3'b010, "R7 resume at period start", {hi, lo}, {3'b001, 3'b010});
      // R2 sanity on resumed drive
      check((hi & lo) == 0, "R2 no shoot-through", hi & lo, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule